// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Modes

This block turns bytes written by a processor into asynchronous serial characters. A write strobe fills a one-character holding register. When the shifter is idle and the line is allowed to send, the held byte moves into the shifter. The holding register can then take the next byte while the current character is still going out. All bit timing comes from a clock enable that pulses at sixteen times the bit rate.

The character format is chosen with three small codes: the word length (5 to 8 bits), the parity (even, odd or none) and the stop length. The format is sampled when each character is loaded.

A two-bit line mode selects one of four behaviours:
- normal sending, held off while clear-to-send is false;
- a break mode that keeps every slot of the character low;
- an echo mode that wires the serial input straight to the serial output and holds back all transmission;
- a loop mode that steers the serial character to an internal receiver path and holds the external line at Mark.

Top module: `uart_tx_line`

## Requirements
- R1: The word length code `wlen_sel` selects 00 = 5, 01 = 6, 10 = 7 and 11 = 8 data bits. Holding-register bits above the selected length are not sent.
- R2: With `stop_sel` = 0 the stop slot lasts 16 ticks. With `stop_sel` = 1 it lasts 24 ticks (1.5 bits) for 5-bit words and 32 ticks (2 bits) for 6, 7 or 8-bit words. The stop level is high.
- R3: Parity code `parity_sel`: 000, 010 and 100 append even parity. 001, 011 and 101 append odd parity. 110 and 111 append no parity bit. Parity covers only the selected data bits.
- R4: A character is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop slot. Every start, data and parity slot lasts 16 ticks of `tick_16x`.
- R5: After reset `sdo` and `loop_sdo` are high, `hold_empty` is 1 and `tx_done` is 1. Outside echo mode `sdo` is high whenever no character is being shifted.
- R6: In normal and break modes a character starts only while `cts_ok` is 1. If `cts_ok` falls during a character, that character completes, and no further character starts until `cts_ok` returns to 1.
- R7: `hold_empty` goes to 0 on the clock after a `hold_wr` strobe. It returns to 1 on the clock in which the held byte moves into the shifter.
- R8: `tx_done` goes to 0 when a character is loaded. It goes to 1 when the stop slot ends while the holding register is empty. It stays 0 between two back-to-back characters.
- R9: Line mode 01 (break): every slot of a loaded character, including stop, is driven low on `sdo`. The low period lasts the full character length.
- R10: Line mode 10 (echo): `sdo` follows `sdi` combinationally and no held byte is loaded. When the mode returns to normal, the held byte is sent.
- R11: Line mode 11 (loop): `sdo` stays high, the character appears on `loop_sdo`, and `cts_ok` has no effect. In the other modes `loop_sdo` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Enable pulsing at 16x the bit rate |
| hold_wr | input | 1 | Holding-register write strobe |
| hold_data | input | DATA_W | Byte written to the holding register |
| wlen_sel | input | 2 | Word length code |
| stop_sel | input | 1 | Stop length select |
| parity_sel | input | 3 | Parity code |
| line_mode | input | 2 | 00 normal, 01 break, 10 echo, 11 loop |
| cts_ok | input | 1 | Clear-to-send, 1 = true |
| sdi | input | 1 | Serial input used by echo mode |
| sdo | output | 1 | Serial output line |
| loop_sdo | output | 1 | Serial character routed to the receiver in loop mode |
| hold_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Shifter finished and holding register empty |

## Verification
The bench builds the block with DATA_W = 8 and TICKS_PER_BIT = 16. It holds `tick_16x` high, so each bit lasts exactly 16 clocks. Under that timing the bench can sample every slot at its midpoint. It can also count the clocks from the start edge to the rise of `tx_done`, which shows whether a stop slot lasted 1, 1.5 or 2 bits. A byte table covers every word length, all six parity-bearing codes and both no-parity codes, in normal and loop modes. Directed runs cover clear-to-send held false, clear-to-send dropped mid-character, back-to-back loading, break and echo.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BREAK  = 2'b01,
    MODE_ECHO   = 2'b10,
    MODE_LOOP   = 2'b11
  } line_mode_e;

  typedef enum logic [1:0] {
    STOP_ONE,
    STOP_ONE_HALF,
    STOP_TWO
  } stop_len_e;

  typedef enum logic [1:0] {
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       has_par;
    logic       odd_par;
    stop_len_e  stop;
  } fmt_t;
endpackage

// File: rtl/utx_fmt_decode.sv
module utx_fmt_decode
  import utx_pkg::*;
(
  input  logic [1:0] wlen_sel,
  input  logic       stop_sel,
  input  logic [2:0] parity_sel,
  output fmt_t       fmt_o
);
  always_comb begin
    fmt_o.wlen    = wlen_sel;
    fmt_o.has_par = !(parity_sel[2] && parity_sel[1]);
    fmt_o.odd_par = parity_sel[0];
    if (!stop_sel)
      fmt_o.stop = STOP_ONE;
    else if (wlen_sel == 2'b00)
      fmt_o.stop = STOP_ONE_HALF;
    else
      fmt_o.stop = STOP_TWO;
  end
endmodule

// File: rtl/utx_frame_ctl.sv
module utx_frame_ctl
  import utx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  fmt_t              fmt_i,
  input  line_mode_e        mode_i,
  input  logic              cts_i,
  output logic              busy_o,
  output logic              line_o,
  output logic              hold_empty_o,
  output logic              done_o
);
  localparam int STOP_MAX = 2 * TICKS_PER_BIT;
  localparam int TW       = $clog2(STOP_MAX + 1);
  localparam int IW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] hold_q, shift_q, mask;
  logic              hold_empty_q, busy_q, line_q, done_q, par_q;
  fmt_t              fmt_q;
  phase_e            phase_q;
  logic [TW-1:0]     tick_q, slot_len;
  logic [IW-1:0]     bit_q;
  logic              start_ok, slot_end, last_bit;

  // data mask for the incoming format (parity is computed at load)
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      mask[i] = (i < (DATA_W - 3 + int'(fmt_i.wlen)));
  end

  always_comb begin
    slot_len = TW'(TICKS_PER_BIT);
    if (phase_q == PH_STOP) begin
      case (fmt_q.stop)
        STOP_ONE_HALF: slot_len = TW'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
        STOP_TWO:      slot_len = TW'(STOP_MAX);
        default:       slot_len = TW'(TICKS_PER_BIT);
      endcase
    end
  end

  assign start_ok = !busy_q && !hold_empty_q && (mode_i != MODE_ECHO) &&
                    (cts_i || (mode_i == MODE_LOOP));
  assign slot_end = busy_q && tick && (tick_q == slot_len - 1'b1);
  assign last_bit = (int'(bit_q) == DATA_W - 4 + int'(fmt_q.wlen));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= '0;
      hold_empty_q <= 1'b1;
      busy_q       <= 1'b0;
      line_q       <= 1'b1;
      done_q       <= 1'b1;
      shift_q      <= '0;
      par_q        <= 1'b0;
      fmt_q        <= '0;
      phase_q      <= PH_START;
      tick_q       <= '0;
      bit_q        <= '0;
    end else begin
      if (hold_wr) hold_q <= hold_data;
      if (hold_wr)       hold_empty_q <= 1'b0;
      else if (start_ok) hold_empty_q <= 1'b1;

      if (start_ok) begin
        busy_q  <= 1'b1;
        done_q  <= 1'b0;
        shift_q <= hold_q;
        par_q   <= (^(hold_q & mask)) ^ fmt_i.odd_par;
        fmt_q   <= fmt_i;
        phase_q <= PH_START;
        tick_q  <= '0;
        bit_q   <= '0;
        line_q  <= 1'b0;
      end else if (slot_end) begin
        tick_q <= '0;
        case (phase_q)
          PH_START: begin
            phase_q <= PH_DATA;
            line_q  <= shift_q[0];
          end
          PH_DATA: begin
            if (last_bit) begin
              phase_q <= fmt_q.has_par ? PH_PAR : PH_STOP;
              line_q  <= fmt_q.has_par ? par_q : 1'b1;
            end else begin
              bit_q   <= bit_q + 1'b1;
              shift_q <= shift_q >> 1;
              line_q  <= shift_q[1];
            end
          end
          PH_PAR: begin
            phase_q <= PH_STOP;
            line_q  <= 1'b1;
          end
          default: begin
            busy_q <= 1'b0;
            line_q <= 1'b1;
            if (hold_empty_q) done_q <= 1'b1;
          end
        endcase
      end else if (busy_q && tick) begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign busy_o       = busy_q;
  assign line_o       = line_q;
  assign hold_empty_o = hold_empty_q;
  assign done_o       = done_q;

  assert_hold_wr_clears_R7: assert property (@(posedge clk) disable iff (rst)
    hold_wr |=> !hold_empty_o);
  assert_cts_blocks_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !cts_i && mode_i != MODE_LOOP) |=> !busy_q);
  assert_echo_holds_byte_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_ECHO && !hold_wr) |=> $stable(hold_empty_q));
  assert_load_clears_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !done_q);
  assert_loop_ignores_cts_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_LOOP && !busy_q && !hold_empty_q) |=> busy_q);
endmodule

// File: rtl/utx_line_sel.sv
module utx_line_sel
  import utx_pkg::*;
(
  input  line_mode_e mode_i,
  input  logic       busy_i,
  input  logic       frame_line_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       loop_o
);
  logic ser;

  assign ser = (mode_i == MODE_BREAK && busy_i) ? 1'b0 : frame_line_i;

  always_comb begin
    case (mode_i)
      MODE_ECHO: sdo_o = sdi_i;
      MODE_LOOP: sdo_o = 1'b1;
      default:   sdo_o = ser;
    endcase
  end

  assign loop_o = (mode_i == MODE_LOOP) ? ser : 1'b1;
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
  import utx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_16x,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [1:0]        wlen_sel,
  input  logic              stop_sel,
  input  logic [2:0]        parity_sel,
  input  logic [1:0]        line_mode,
  input  logic              cts_ok,
  input  logic              sdi,
  output logic              sdo,
  output logic              loop_sdo,
  output logic              hold_empty,
  output logic              tx_done
);
  fmt_t       fmt;
  line_mode_e mode;
  logic       busy, frame_line;

  assign mode = line_mode_e'(line_mode);

  utx_fmt_decode u_dec (
    .wlen_sel   (wlen_sel),
    .stop_sel   (stop_sel),
    .parity_sel (parity_sel),
    .fmt_o      (fmt)
  );

  utx_frame_ctl #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick_16x),
    .hold_wr      (hold_wr),
    .hold_data    (hold_data),
    .fmt_i        (fmt),
    .mode_i       (mode),
    .cts_i        (cts_ok),
    .busy_o       (busy),
    .line_o       (frame_line),
    .hold_empty_o (hold_empty),
    .done_o       (tx_done)
  );

  utx_line_sel u_sel (
    .mode_i       (mode),
    .busy_i       (busy),
    .frame_line_i (frame_line),
    .sdi_i        (sdi),
    .sdo_o        (sdo),
    .loop_o       (loop_sdo)
  );

  assert_idle_mark_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && mode != MODE_ECHO) |-> sdo);
  assert_break_low_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BREAK && busy) |-> !sdo);
endmodule

// File: tb/uart_tx_line_tb.sv
module uart_tx_line_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1, tick_16x = 1'b1, hold_wr = 1'b0;
  logic [7:0] hold_data = '0;
  logic [1:0] wlen_sel = 2'b11, line_mode = 2'b00;
  logic       stop_sel = 1'b0, cts_ok = 1'b1, sdi = 1'b1;
  logic [2:0] parity_sel = 3'b110;
  logic       sdo, loop_sdo, hold_empty, tx_done;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_tx_line #(.DATA_W(8), .TICKS_PER_BIT(16)) dut_i (
    .clk(clk), .rst(rst), .tick_16x(tick_16x), .hold_wr(hold_wr),
    .hold_data(hold_data), .wlen_sel(wlen_sel), .stop_sel(stop_sel),
    .parity_sel(parity_sel), .line_mode(line_mode), .cts_ok(cts_ok),
    .sdi(sdi), .sdo(sdo), .loop_sdo(loop_sdo), .hold_empty(hold_empty),
    .tx_done(tx_done)
  );

  // {loop, parity[2:0], stop, wlen[1:0], data[7:0]}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 3'b110, 1'b0, 2'b11, 8'hA5},
    {1'b0, 3'b000, 1'b1, 2'b11, 8'h3C},
    {1'b0, 3'b001, 1'b1, 2'b00, 8'h13},
    {1'b0, 3'b011, 1'b1, 2'b01, 8'hFF},
    {1'b0, 3'b010, 1'b0, 2'b10, 8'h7E},
    {1'b0, 3'b100, 1'b0, 2'b00, 8'h0A},
    {1'b1, 3'b101, 1'b0, 2'b11, 8'h00},
    {1'b1, 3'b111, 1'b1, 2'b10, 8'h55}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(inout int c);
    @(negedge clk);
    c++;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    hold_wr = 1'b1; hold_data = d;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  function automatic logic cur_line(input bit lp);
    return lp ? loop_sdo : sdo;
  endfunction

  task automatic capture(input bit lp, input logic [7:0] d, input logic [1:0] wl,
                         input bit st, input logic [2:0] pc, input bit want_done);
    int nb = 5 + int'(wl);
    bit hp = (pc[2:1] != 2'b11);
    int stop_t = !st ? 16 : (wl == 2'b00 ? 24 : 32);
    int tot = 16 * (1 + nb + int'(hp)) + stop_t;
    logic pbit = 1'b0;
    int cnt = 0, guard = 0;
    for (int i = 0; i < nb; i++) pbit ^= d[i];
    pbit ^= pc[0];
    while (cur_line(lp) !== 1'b0 && guard < 3000) begin
      @(negedge clk); guard++;
    end
    chk(guard < 3000, "R4 start seen", guard, 0);
    repeat (8) step(cnt);
    chk(cur_line(lp) === 1'b0, "R4 start level", int'(cur_line(lp)), 0);
    if (lp) chk(sdo === 1'b1, "R11 sdo mark in loop", int'(sdo), 1);
    for (int i = 0; i < nb; i++) begin
      repeat (16) step(cnt);
      chk(cur_line(lp) === d[i], "R1 R4 data bit", int'(cur_line(lp)), int'(d[i]));
    end
    if (hp) begin
      repeat (16) step(cnt);
      chk(cur_line(lp) === pbit, "R3 parity bit", int'(cur_line(lp)), int'(pbit));
    end
    repeat (16) step(cnt);
    chk(cur_line(lp) === 1'b1, "R2 stop level", int'(cur_line(lp)), 1);
    if (lp) chk(sdo === 1'b1, "R11 sdo mark in loop", int'(sdo), 1);
    if (want_done) begin
      while (tx_done !== 1'b1 && cnt < tot + 50) step(cnt);
      chk(cnt == tot, "R2 R8 character length to done", cnt, tot);
    end else begin
      chk(tx_done === 1'b0, "R8 done held low", int'(tx_done), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, zb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R5 R7 R8
    chk(sdo === 1'b1, "R5 sdo after reset", int'(sdo), 1);
    chk(loop_sdo === 1'b1, "R5 loop_sdo after reset", int'(loop_sdo), 1);
    chk(hold_empty === 1'b1, "R5 R7 hold_empty after reset", int'(hold_empty), 1);
    chk(tx_done === 1'b1, "R5 R8 tx_done after reset", int'(tx_done), 1);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [14:0] e = VEC[v];
      @(negedge clk);
      line_mode = e[14] ? 2'b11 : 2'b00;
      cts_ok = !e[14];
      parity_sel = e[13:11]; stop_sel = e[10]; wlen_sel = e[9:8];
      wr_byte(e[7:0]);
      chk(hold_empty === 1'b0, "R7 cleared by write", int'(hold_empty), 0);
      @(negedge clk);
      chk(hold_empty === 1'b1, "R7 set on transfer", int'(hold_empty), 1);
      chk(tx_done === 1'b0, "R8 cleared on load", int'(tx_done), 0);
      capture(e[14], e[7:0], e[9:8], e[10], e[13:11], 1'b1);
      chk(loop_sdo === 1'b1, "R11 loop_sdo idle", int'(loop_sdo), 1);
    end
    line_mode = 2'b00; cts_ok = 1'b1;
    wlen_sel = 2'b11; stop_sel = 1'b0; parity_sel = 3'b110;

    // R6: CTS held false
    cts_ok = 1'b0;
    wr_byte(8'h96);
    zb = 0;
    repeat (40) begin @(negedge clk); if (sdo !== 1'b1) zb++; end
    chk(zb == 0, "R6 no start while CTS false", zb, 0);
    chk(hold_empty === 1'b0, "R6 byte still held", int'(hold_empty), 0);
    cts_ok = 1'b1;
    capture(1'b0, 8'h96, 2'b11, 1'b0, 3'b110, 1'b1);

    // R6: CTS dropped mid-character
    wr_byte(8'h69);
    fork
      capture(1'b0, 8'h69, 2'b11, 1'b0, 3'b110, 1'b1);
      begin repeat (30) @(negedge clk); cts_ok = 1'b0; end
    join
    wr_byte(8'h11);
    zb = 0;
    repeat (40) begin @(negedge clk); if (sdo !== 1'b1) zb++; end
    chk(zb == 0, "R6 next char waits for CTS", zb, 0);
    chk(hold_empty === 1'b0, "R6 next byte held", int'(hold_empty), 0);
    cts_ok = 1'b1;
    capture(1'b0, 8'h11, 2'b11, 1'b0, 3'b110, 1'b1);

    // R7 R8: back-to-back characters
    wr_byte(8'hA1);
    @(negedge clk);
    wr_byte(8'h3E);
    chk(hold_empty === 1'b0, "R7 second byte held", int'(hold_empty), 0);
    capture(1'b0, 8'hA1, 2'b11, 1'b0, 3'b110, 1'b0);
    chk(hold_empty === 1'b0, "R7 held through first char", int'(hold_empty), 0);
    capture(1'b0, 8'h3E, 2'b11, 1'b0, 3'b110, 1'b1);
    chk(hold_empty === 1'b1, "R7 empty after both", int'(hold_empty), 1);

    // R9: break
    line_mode = 2'b01;
    wr_byte(8'hFF);
    @(negedge clk);
    n = 0; zb = 0;
    while (tx_done !== 1'b1 && n < 1000) begin
      if (sdo !== 1'b0) zb++;
      @(negedge clk); n++;
    end
    chk(zb == 0, "R9 all slots low", zb, 0);
    chk(n == 160, "R9 break length", n, 160);
    chk(sdo === 1'b1, "R5 mark after break char", int'(sdo), 1);

    // R10: echo
    line_mode = 2'b10;
    wr_byte(8'hC3);
    zb = 0;
    repeat (60) begin @(negedge clk); if (hold_empty !== 1'b0) zb++; end
    chk(zb == 0, "R10 no load in echo", zb, 0);
    sdi = 1'b0; #1;
    chk(sdo === 1'b0, "R10 sdo follows sdi low", int'(sdo), 0);
    sdi = 1'b1; #1;
    chk(sdo === 1'b1, "R10 sdo follows sdi high", int'(sdo), 1);
    @(negedge clk);
    line_mode = 2'b00;
    capture(1'b0, 8'hC3, 2'b11, 1'b0, 3'b110, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule